// File: doc/BRIEF.md
# Compare Channel with Per-Period Match Blocking

This block is one compare channel that watches an external 16-bit up-counting timer. The timer counts up to FFFFh and then reloads from a programmable start value, so each timer period runs from that start value to FFFFh. The timer sends its count and a one-cycle overflow strobe, and the strobe is high while the count sits at FFFFh. The channel holds a 16-bit compare register that software writes through a simple write port. When the timer equals the compare value, the channel raises a one-cycle interrupt request. In output mode it also sets an output pin, which the next overflow clears. This gives a PWM waveform whose duty cycle follows the compare value.

Only the first match in a period counts. After that match the channel is blocked until the next overflow re-arms it. Software can therefore rewrite the compare value at any point, higher or lower than the current count, and the new value only acts from the following period onward. If the register is rewritten before the period's first match, the old value never fires and the new value is the one that matches.

Control is a small state machine with three states:
- `ST_OFF`: the channel is disabled.
- `ST_ARMED`: a match will be accepted.
- `ST_HIT`: a match has been taken and further matches are blocked.

The transitions are:
- enable: `ST_OFF` to `ST_ARMED` on a mode change to an active mode.
- take: `ST_ARMED` to `ST_HIT` on an accepted match without overflow.
- take-and-rearm: `ST_ARMED` stays in `ST_ARMED` when an accepted match coincides with overflow.
- rearm: `ST_HIT` to `ST_ARMED` on overflow.
- reconfigure: any state goes to `ST_ARMED` or `ST_OFF` on any mode change, depending on the new mode.

Top module: `cmpb_channel`

## Requirements
- R1: After reset, `irq_o` and `out_o` are 0, the compare register holds 0000h and the channel is disabled.
- R2: `mode_i` is encoded as follows: 2'b00 is off, 2'b01 is interrupt only, 2'b10 is interrupt plus output, and 2'b11 is treated as off. While the registered mode is off, no interrupt is raised and `out_o` is 0.
- R3: When `wr_en_i` is high at a clock edge, `wr_data_i` is loaded into the compare register. The new value is used for comparison from the next cycle on. A write in the same cycle as a match does not change that cycle's comparison.
- R4: An accepted match is a cycle in which `tmr_i` equals the compare register, the channel is armed, and `mode_i` equals the registered active mode. Each accepted match produces `irq_o` high for exactly the one following cycle.
- R5: After an accepted match without overflow, no further match is accepted until an overflow strobe is seen. This holds even if the compare register is rewritten to a count still ahead in the period.
- R6: An overflow strobe re-arms the channel for the next period. A match coinciding with the overflow (compare value FFFFh) is accepted, and the channel is armed afterwards.
- R7: If the compare register is rewritten before the period's first match, the old value raises no interrupt in that period and the new value matches.
- R8: In output mode, `out_o` goes to 1 in the cycle after an accepted match and to 0 in the cycle after an overflow without an accepted match. When both happen in the same cycle, the set wins.
- R9: In interrupt-only mode, `out_o` stays 0.
- R10: In a cycle where `mode_i` differs from the registered mode, no match is accepted. The block condition is then cleared and `out_o` becomes 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_i | input | 16 | Current timer count |
| tmr_ovf_i | input | 1 | Timer overflow strobe, high while count is FFFFh |
| wr_en_i | input | 1 | Compare register write enable |
| wr_data_i | input | 16 | Compare register write value |
| mode_i | input | 2 | Channel mode (see R2) |
| irq_o | output | 1 | One-cycle interrupt request |
| out_o | output | 1 | Compare output pin |

## Verification
The assertions assume a well-behaved timer:
- The overflow strobe appears only once per period.
- The count stays inside the reload-to-FFFFh window.
- After an accepted match there is no second equal count in the same period, unless an overflow intervenes.

The stimulus keeps to these assumptions. It derives the count and the strobe from a bench-side timer model that counts from a chosen reload value to FFFFh. It changes the reload value only at overflow. Random compare writes and rare mode changes are layered on top, around directed cases for the FFFFh match, rewrites before and after a match, and mid-period mode changes.

// File: rtl/cmpb_pkg.sv
`timescale 1ns/1ps
package cmpb_pkg;
    localparam int unsigned CW = 16;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_IRQ  = 2'b01,
        MD_PWM  = 2'b10,
        MD_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_ARMED = 2'b01,
        ST_HIT   = 2'b10
    } state_e;

    function automatic logic mode_active(input logic [1:0] m);
        return (m == MD_IRQ) || (m == MD_PWM);
    endfunction
endpackage

// File: rtl/cmpb_reg.sv
`timescale 1ns/1ps
module cmpb_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] tmr_i,
    output logic [W-1:0] cmp_o,
    output logic         eq_o
);
    logic [W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmp_q <= '0;
        else if (wr_en_i) cmp_q <= wr_data_i;
    end

    assign cmp_o = cmp_q;
    assign eq_o  = (tmr_i == cmp_q);

    // R3
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cmp_q == $past(wr_data_i)));
endmodule

// File: rtl/cmpb_fsm.sv
`timescale 1ns/1ps
module cmpb_fsm
    import cmpb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eq_i,
    input  logic       ovf_i,
    input  logic [1:0] mode_i,
    output logic [1:0] mode_q_o,
    output logic       chg_o,
    output logic       accept_o
);
    state_e     state_q, state_d;
    logic [1:0] mode_q;
    logic       chg;
    logic       accept;

    assign chg    = (mode_i != mode_q);
    assign accept = (state_q == ST_ARMED) && !chg && eq_i;

    always_comb begin
        state_d = state_q;
        if (chg) begin
            state_d = mode_active(mode_i) ? ST_ARMED : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_ARMED: state_d = (accept && !ovf_i) ? ST_HIT : ST_ARMED;
                ST_HIT:   state_d = ovf_i ? ST_ARMED : ST_HIT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= MD_OFF;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_i;
        end
    end

    assign mode_q_o = mode_q;
    assign chg_o    = chg;
    assign accept_o = accept;

    // R5
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ovf_i) |=> !accept);
    // R6
    ovf_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !chg && mode_active(mode_q)) |=> (state_q == ST_ARMED));
    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active(mode_q) |-> !accept);
endmodule

// File: rtl/cmpb_drv.sv
`timescale 1ns/1ps
module cmpb_drv
    import cmpb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       ovf_i,
    input  logic       chg_i,
    input  logic [1:0] mode_q_i,
    output logic       irq_o,
    output logic       out_o
);
    logic irq_q, out_q, out_d;

    always_comb begin
        out_d = 1'b0;
        if (!chg_i && mode_q_i == MD_PWM) begin
            if (accept_i)   out_d = 1'b1;
            else if (ovf_i) out_d = 1'b0;
            else            out_d = out_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            irq_q <= accept_i;
            out_q <= out_d;
        end
    end

    assign irq_o = irq_q;
    assign out_o = out_q;

    // R8
    pwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && mode_q_i == MD_PWM) |=> out_q);
    // R9
    irq_only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q_i != MD_PWM) |-> !out_q);
    // R10
    chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> (!out_q && !irq_q));
endmodule

// File: rtl/cmpb_channel.sv
`timescale 1ns/1ps
module cmpb_channel
    import cmpb_pkg::*;
#(
    parameter int unsigned W = CW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tmr_i,
    input  logic         tmr_ovf_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [1:0]   mode_i,
    output logic         irq_o,
    output logic         out_o
);
    logic [W-1:0] cmp_val;
    logic         eq;
    logic [1:0]   mode_q;
    logic         chg;
    logic         accept;

    cmpb_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .tmr_i     (tmr_i),
        .cmp_o     (cmp_val),
        .eq_o      (eq)
    );

    cmpb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .eq_i     (eq),
        .ovf_i    (tmr_ovf_i),
        .mode_i   (mode_i),
        .mode_q_o (mode_q),
        .chg_o    (chg),
        .accept_o (accept)
    );

    cmpb_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .ovf_i    (tmr_ovf_i),
        .chg_i    (chg),
        .mode_q_i (mode_q),
        .irq_o    (irq_o),
        .out_o    (out_o)
    );

    // R4
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> mode_active($past(mode_i)));
    // R7
    irq_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(tmr_i) == $past(cmp_val)));
endmodule

// File: tb/cmpb_channel_bench.sv
`timescale 1ns/1ps
module cmpb_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_i = '0;
    logic        tmr_ovf_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        irq_o, out_o;

    int checks = 0;
    int failures = 0;

    logic [15:0] tmr, reload;
    logic [15:0] m_cmp;
    logic [1:0]  m_mode;
    logic        m_blk, m_out, e_irq, e_out;

    always #10 clk = ~clk;

    cmpb_channel u_cmpb_channel (
        .clk(clk), .rst_n(rst_n), .tmr_i(tmr_i), .tmr_ovf_i(tmr_ovf_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .mode_i(mode_i),
        .irq_o(irq_o), .out_o(out_o)
    );

    function automatic logic active(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic wr, input logic [15:0] d, input logic [1:0] md, input string tag);
        logic ovf, chg, match;
        @(negedge clk);
        ovf = (tmr == 16'hFFFF);
        tmr_i = tmr; tmr_ovf_i = ovf; wr_en_i = wr; wr_data_i = d; mode_i = md;
        chg   = (md != m_mode);
        match = !chg && active(m_mode) && !m_blk && (tmr == m_cmp);
        e_irq = match;
        if (chg) begin
            m_blk = 1'b0; m_out = 1'b0;
        end else begin
            m_blk = ovf ? 1'b0 : (m_blk | match);
            if (m_mode == 2'b10) m_out = match ? 1'b1 : (ovf ? 1'b0 : m_out);
            else                 m_out = 1'b0;
        end
        e_out  = m_out;
        m_mode = md;
        if (wr) m_cmp = d;
        @(posedge clk); #5;
        chk(tag, irq_o, e_irq, "irq");
        chk(tag, out_o, e_out, "out");
        tmr = ovf ? reload : tmr + 16'd1;
    endtask

    task automatic idle(input int n, input logic [1:0] md, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, md, tag);
    endtask

    task automatic to_top(input logic [1:0] md, input string tag);
        while (tmr != 16'hFFFF) step(1'b0, 16'h0, md, tag);
        step(1'b0, 16'h0, md, tag);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned seed;
        int irq_cnt;
        seed = $urandom(1234);
        tmr = 16'hFFF9; reload = 16'hFFF9;
        m_cmp = '0; m_mode = 2'b00; m_blk = 1'b0; m_out = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", irq_o, 1'b0, "irq after reset");
        chk("R1", out_o, 1'b0, "out after reset");
        @(negedge clk); rst_n = 1'b1;

        // R2: disabled channel, compare at a reachable count
        step(1'b1, 16'hFFFB, 2'b00, "R3");
        idle(10, 2'b00, "R2");
        idle(8, 2'b11, "R2");
        // align to period start, enable interrupt-only
        to_top(2'b01, "R10");
        // R4, R9: single accepted match at FFFB
        irq_cnt = 0;
        for (int i = 0; i < 7; i++) begin
            step(1'b0, 16'h0, 2'b01, "R4");
            irq_cnt += irq_o;
        end
        chk("R4", irq_cnt == 1, 1'b1, "one irq per period");
        chk("R9", out_o, 1'b0, "irq-only pin");
        // R5: rewrite after match to a count ahead, same period -> blocked
        tmr = 16'hFFF9;
        step(1'b1, 16'hFFFA, 2'b01, "R3");
        step(1'b0, 16'h0, 2'b01, "R4");
        step(1'b1, 16'hFFFE, 2'b01, "R5");
        irq_cnt = 0;
        while (tmr != 16'hFFF9) begin step(1'b0, 16'h0, 2'b01, "R5"); irq_cnt += irq_o; end
        chk("R5", irq_cnt == 0, 1'b1, "no irq after blocked rewrite");
        // next period: FFFE fires
        irq_cnt = 0;
        for (int i = 0; i < 7; i++) begin step(1'b0, 16'h0, 2'b01, "R6"); irq_cnt += irq_o; end
        chk("R6", irq_cnt == 1, 1'b1, "rearmed after overflow");
        // R7: rewrite FFFA -> FFFC before match
        step(1'b1, 16'hFFFA, 2'b01, "R7");
        to_top(2'b01, "R7");
        step(1'b1, 16'hFFFC, 2'b01, "R7");
        irq_cnt = 0;
        while (tmr != 16'hFFF9) begin step(1'b0, 16'h0, 2'b01, "R7"); irq_cnt += irq_o; end
        chk("R7", irq_cnt == 1, 1'b1, "only new value fires");
        // R6: compare at FFFF coinciding with overflow, two periods
        step(1'b1, 16'hFFFF, 2'b01, "R6");
        irq_cnt = 0;
        for (int i = 0; i < 14; i++) begin step(1'b0, 16'h0, 2'b01, "R6"); irq_cnt += irq_o; end
        chk("R6", irq_cnt == 2, 1'b1, "FFFF match each period");
        // R8: output mode, PWM at FFFC
        step(1'b1, 16'hFFFC, 2'b10, "R10");
        idle(30, 2'b10, "R8");
        step(1'b1, 16'hFFFF, 2'b10, "R8");
        idle(16, 2'b10, "R8");
        // R10: mode change mid-period with pin high
        step(1'b1, 16'hFFFA, 2'b10, "R8");
        to_top(2'b10, "R8");
        idle(3, 2'b10, "R8");
        step(1'b0, 16'h0, 2'b01, "R10");
        chk("R10", out_o, 1'b0, "pin cleared on mode change");
        step(1'b0, 16'h0, 2'b10, "R10");
        idle(20, 2'b10, "R10");

        // random phase
        for (int n = 0; n < 6000; n++) begin
            logic        wr;
            logic [15:0] d;
            logic [1:0]  md;
            wr = ($urandom % 12) == 0;
            d  = reload + 16'($urandom % (17'h10000 - {1'b0, reload}));
            md = m_mode;
            if (($urandom % 150) == 0) md = 2'($urandom % 4);
            if (tmr == 16'hFFFF && ($urandom % 4) == 0)
                reload = 16'hFFFF - 16'($urandom % 24);
            step(wr, d, md, "R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule